// File: doc/BRIEF.md
# LCD Segment Waveform Selector

This block produces the logic-level drive for a row of LCD segment outputs (160 by default). Each segment is shown as a phase relation to the common electrode that is active at the moment. A lit segment drives the inverse of that common's phase, so the cell sees AC drive. A dark segment drives the same phase as the common, so the cell sees no net voltage. The common phase and the A/B selection come from the common timing block. The display data comes from two latch banks. The analog level shifters that follow are not part of this block.

A small source state machine chooses what every lane shows in the next cycle. It has four states:

| State | Meaning |
|-------|---------|
| `ST_BANK_A` | each lane shows bank A (the reset state) |
| `ST_BANK_B` | each lane shows bank B |
| `ST_ALL_ON` | every lane is forced lit |
| `ST_ALL_OFF` | every lane is forced dark |

The next state is decided on every rising clock edge by a fixed priority. Each transition goes to the named state from any state:

| Transition | Condition |
|------------|-----------|
| `TR_TEST` | to `ST_ALL_ON` when the test input is high |
| `TR_BLANK` | to `ST_ALL_OFF` when blank is high and test is low |
| `TR_SEL_B` | to `ST_BANK_B` in half-duty mode while common B is selected |
| `TR_SEL_A` | to `ST_BANK_A` in every other case |

The common phase is registered on the same edge as the state, so segment and common transitions line up in the same cycle. The test and blank inputs are also repeated on outputs that feed the next cascaded device.

Top module: `lcd_seg_selector`

## Requirements
- R1: While `rst_n` is low, every bit of `seg_out` is 0.
- R2: In static mode (`half_duty_en`=0), with test and blank low, `seg_out[n]` after a rising edge equals `com_phase` XOR `bank_a[n]` as sampled at that edge. `com_b_sel` has no effect in this mode.
- R3: In half-duty mode with `com_b_sel`=0 (common A selected), and with test and blank low, `seg_out[n]` after an edge equals `com_phase` XOR `bank_a[n]` as sampled at that edge.
- R4: In half-duty mode with `com_b_sel`=1 (common B selected), and with test and blank low, `seg_out[n]` after an edge equals `com_phase` XOR `bank_b[n]` as sampled at that edge.
- R5: When `test_all_on`=1 at an edge, every bit of `seg_out` after that edge equals the inverse of the sampled `com_phase`. This holds whatever the bank data, the mode and `blank_all_off` are.
- R6: When `blank_all_off`=1 and `test_all_on`=0 at an edge, every bit of `seg_out` after that edge equals the sampled `com_phase`, whatever the bank data.
- R7: `test_all_on_thru` always equals `test_all_on`, and `blank_all_off_thru` always equals `blank_all_off`, with no clock delay.
- R8: `seg_out` changes only at a rising clock edge or at reset. Input changes between edges leave it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock shared with the common generator |
| rst_n | input | 1 | asynchronous reset, active low |
| half_duty_en | input | 1 | 1 = half-duty mode, 0 = static mode |
| com_phase | input | 1 | logic phase of the currently selected common |
| com_b_sel | input | 1 | 1 = common B selected, 0 = common A selected |
| bank_a | input | N | display latch bank A, bit n for segment n |
| bank_b | input | N | display latch bank B, bit n for segment n |
| test_all_on | input | 1 | forces every segment lit |
| blank_all_off | input | 1 | forces every segment dark when test is low |
| seg_out | output | N | segment drive, registered |
| test_all_on_thru | output | 1 | repeat of `test_all_on` for cascading |
| blank_all_off_thru | output | 1 | repeat of `blank_all_off` for cascading |

## Verification
Two functions can fall in the same cycle: the all-on test override and the all-off blank override. A third case overlaps with them: a half-duty bank swap can arrive on the same edge as an override is raised. The stimulus table drives test and blank high together, in both modes and with both common selections, and with bank data chosen so that either bank would light some lanes. The expected result is taken from the priority order: test wins over blank, and both win over the bank choice. Each lane is compared against the sampled common phase, XORed with the bit that survives the overrides.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

    typedef enum logic [1:0] {
        ST_BANK_A  = 2'd0,
        ST_BANK_B  = 2'd1,
        ST_ALL_ON  = 2'd2,
        ST_ALL_OFF = 2'd3
    } src_state_t;

endpackage

// File: rtl/seg_src_fsm.sv
module seg_src_fsm
    import lcd_seg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_duty_en,
    input  logic       com_b_sel,
    input  logic       test_all_on,
    input  logic       blank_all_off,
    output src_state_t state_nx,
    output src_state_t state_q
);

    // Next-state logic: fixed override priority, then bank choice
    always_comb begin
        if (test_all_on) begin
            state_nx = ST_ALL_ON;                  // TR_TEST
        end else if (blank_all_off) begin
            state_nx = ST_ALL_OFF;                 // TR_BLANK
        end else if (half_duty_en && com_b_sel) begin
            state_nx = ST_BANK_B;                  // TR_SEL_B
        end else begin
            state_nx = ST_BANK_A;                  // TR_SEL_A
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BANK_A;
        end else begin
            state_q <= state_nx;
        end
    end

endmodule

// File: rtl/seg_lane.sv
module seg_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic take_b,
    input  logic bit_a,
    input  logic bit_b,
    output logic bit_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= take_b ? bit_b : bit_a;
        end
    end

endmodule

// File: rtl/lcd_seg_selector.sv
module lcd_seg_selector
    import lcd_seg_pkg::*;
#(
    parameter int N = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         half_duty_en,
    input  logic         com_phase,
    input  logic         com_b_sel,
    input  logic [N-1:0] bank_a,
    input  logic [N-1:0] bank_b,
    input  logic         test_all_on,
    input  logic         blank_all_off,
    output logic [N-1:0] seg_out,
    output logic         test_all_on_thru,
    output logic         blank_all_off_thru
);

    localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

    src_state_t   state_nx;
    src_state_t   state_q;
    logic         phase_q;
    logic         take_b;
    logic [N-1:0] data_q;

    seg_src_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_duty_en  (half_duty_en),
        .com_b_sel     (com_b_sel),
        .test_all_on   (test_all_on),
        .blank_all_off (blank_all_off),
        .state_nx      (state_nx),
        .state_q       (state_q)
    );

    assign take_b = (state_nx == ST_BANK_B);

    // Common phase captured on the same edge as the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= com_phase;
        end
    end

    // One data flop per segment lane
    for (genvar g = 0; g < N; g++) begin : g_lane
        seg_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .take_b(take_b),
            .bit_a (bank_a[g]),
            .bit_b (bank_b[g]),
            .bit_q (data_q[g])
        );
    end

    // Output process: the state chooses the effective lane data
    always_comb begin
        unique case (state_q)
            ST_ALL_ON:  seg_out = phase_q ? '0 : ALL_ONES;
            ST_ALL_OFF: seg_out = phase_q ? ALL_ONES : '0;
            ST_BANK_A,
            ST_BANK_B:  seg_out = data_q ^ (phase_q ? ALL_ONES : '0);
            default:    seg_out = '0;
        endcase
    end

    // Cascade repeats
    assign test_all_on_thru   = test_all_on;
    assign blank_all_off_thru = blank_all_off;

endmodule

// File: rtl/lcd_seg_selector_chk.sv
module lcd_seg_selector_chk #(
    parameter int N = 160
) (
    input logic         clk,
    input logic         rst_n,
    input logic         half_duty_en,
    input logic         com_phase,
    input logic         com_b_sel,
    input logic [N-1:0] bank_a,
    input logic [N-1:0] bank_b,
    input logic         test_all_on,
    input logic         blank_all_off,
    input logic [N-1:0] seg_out,
    input logic         test_all_on_thru,
    input logic         blank_all_off_thru
);

    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |-> (seg_out == '0));

    assert_static_bank_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_duty_en && !test_all_on && !blank_all_off)
        |=> (seg_out == ($past(bank_a) ^ {N{$past(com_phase)}})));

    assert_half_bank_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duty_en && !com_b_sel && !test_all_on && !blank_all_off)
        |=> (seg_out == ($past(bank_a) ^ {N{$past(com_phase)}})));

    assert_half_bank_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duty_en && com_b_sel && !test_all_on && !blank_all_off)
        |=> (seg_out == ($past(bank_b) ^ {N{$past(com_phase)}})));

    assert_test_all_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        test_all_on |=> (seg_out == {N{!$past(com_phase)}}));

    assert_blank_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_all_off && !test_all_on) |=> (seg_out == {N{$past(com_phase)}}));

    assert_cascade_thru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_all_on_thru == test_all_on) && (blank_all_off_thru == blank_all_off));

endmodule

bind lcd_seg_selector lcd_seg_selector_chk #(.N(N)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .half_duty_en      (half_duty_en),
    .com_phase         (com_phase),
    .com_b_sel         (com_b_sel),
    .bank_a            (bank_a),
    .bank_b            (bank_b),
    .test_all_on       (test_all_on),
    .blank_all_off     (blank_all_off),
    .seg_out           (seg_out),
    .test_all_on_thru  (test_all_on_thru),
    .blank_all_off_thru(blank_all_off_thru)
);

// File: tb/lcd_seg_selector_tb_top.sv
module lcd_seg_selector_tb_top;

    localparam int N      = 160;
    localparam int PERIOD = 10;

    // Vector fields: [7] half_duty, [6] com_b_sel, [5] phase,
    // [4] test, [3] blank, [2:0] data pattern seed
    localparam int NVEC = 20;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b0_0_0_0_0_001, 8'b0_1_1_0_0_010, 8'b0_0_1_0_0_011, 8'b0_1_0_0_0_100,
        8'b1_0_0_0_0_101, 8'b1_0_1_0_0_110, 8'b1_1_0_0_0_111, 8'b1_1_1_0_0_001,
        8'b0_0_0_1_0_010, 8'b1_1_1_1_0_011, 8'b0_0_1_0_1_100, 8'b1_1_0_0_1_101,
        8'b0_0_0_1_1_110, 8'b0_1_1_1_1_111, 8'b1_0_0_1_1_001, 8'b1_1_1_1_1_010,
        8'b1_0_1_1_1_011, 8'b1_1_0_1_1_100, 8'b1_0_1_0_0_000, 8'b1_1_0_0_0_000
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         half_duty_en;
    logic         com_phase;
    logic         com_b_sel;
    logic [N-1:0] bank_a;
    logic [N-1:0] bank_b;
    logic         test_all_on;
    logic         blank_all_off;
    logic [N-1:0] seg_out;
    logic         test_all_on_thru;
    logic         blank_all_off_thru;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    lcd_seg_selector #(.N(N)) dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .half_duty_en      (half_duty_en),
        .com_phase         (com_phase),
        .com_b_sel         (com_b_sel),
        .bank_a            (bank_a),
        .bank_b            (bank_b),
        .test_all_on       (test_all_on),
        .blank_all_off     (blank_all_off),
        .seg_out           (seg_out),
        .test_all_on_thru  (test_all_on_thru),
        .blank_all_off_thru(blank_all_off_thru)
    );

    function automatic logic [N-1:0] make_pattern(input int seed);
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) begin
            p[i] = (((i * (seed + 3)) + (i >> 2) + seed) % 3) == 0;
        end
        return p;
    endfunction

    function automatic logic [N-1:0] model(input logic half, input logic selb,
                                           input logic ph, input logic tst,
                                           input logic blk, input logic [N-1:0] a,
                                           input logic [N-1:0] b);
        logic [N-1:0] lit;
        if (tst) begin
            lit = {N{1'b1}};
        end else if (blk) begin
            lit = '0;
        end else if (half && selb) begin
            lit = b;
        end else begin
            lit = a;
        end
        return lit ^ {N{ph}};
    endfunction

    task automatic check_vec(input string req, input logic [N-1:0] act,
                             input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: seg_out=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] exp;
        string        tag;
        rst_n         = 1'b0;
        half_duty_en  = 1'b0;
        com_phase     = 1'b1;
        com_b_sel     = 1'b0;
        bank_a        = make_pattern(1);
        bank_b        = make_pattern(2);
        test_all_on   = 1'b1;
        blank_all_off = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs dark while reset is held, even with test high
        check_vec("R1", seg_out, '0);
        rst_n = 1'b1;
        test_all_on = 1'b0;

        // Table walk: drive at a falling edge, check at the next falling edge
        for (int k = 0; k < NVEC; k++) begin
            half_duty_en  = VEC[k][7];
            com_b_sel     = VEC[k][6];
            com_phase     = VEC[k][5];
            test_all_on   = VEC[k][4];
            blank_all_off = VEC[k][3];
            bank_a        = make_pattern(int'(VEC[k][2:0]));
            bank_b        = make_pattern(int'(VEC[k][2:0]) + 4);
            #1;
            check_bit("R7 test", test_all_on_thru, test_all_on);
            check_bit("R7 blank", blank_all_off_thru, blank_all_off);
            exp = model(half_duty_en, com_b_sel, com_phase, test_all_on,
                        blank_all_off, bank_a, bank_b);
            if (test_all_on)             tag = "R5";
            else if (blank_all_off)      tag = "R6";
            else if (!half_duty_en)      tag = "R2";
            else if (com_b_sel)          tag = "R4";
            else                         tag = "R3";
            @(negedge clk);
            check_vec(tag, seg_out, exp);
        end

        // R8: input change between edges leaves output unchanged
        exp = seg_out;
        com_phase    = ~com_phase;
        bank_a       = ~bank_a;
        bank_b       = ~bank_b;
        test_all_on  = 1'b1;
        #1;
        check_vec("R8 hold", seg_out, exp);
        @(posedge clk);
        #1;
        check_vec("R8 edge", seg_out, {N{~com_phase}});

        // R2: static mode ignores com_b_sel
        @(negedge clk);
        test_all_on  = 1'b0;
        half_duty_en = 1'b0;
        com_b_sel    = 1'b1;
        com_phase    = 1'b0;
        bank_a       = make_pattern(5);
        bank_b       = ~make_pattern(5);
        @(negedge clk);
        check_vec("R2 selb ignored", seg_out, make_pattern(5));

        // R3/R4: alternating common selection in half-duty mode
        half_duty_en = 1'b1;
        for (int f = 0; f < 4; f++) begin
            com_b_sel = f[0];
            com_phase = f[1];
            @(negedge clk);
            exp = (f[0] ? ~make_pattern(5) : make_pattern(5)) ^ {N{f[1]}};
            check_vec(f[0] ? "R4 frame" : "R3 frame", seg_out, exp);
        end

        // R1: mid-run reset clears the outputs at once
        #1;
        rst_n = 1'b0;
        #1;
        check_vec("R1 midrun", seg_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule